// File: doc/BRIEF.md
# Exception and Special-Register Unit

This unit keeps the processor's special registers: the page register for the program counter, the saved program counter, the saved status word, a scratch register for handlers, the number of the latest exception and the vector table base. It carries out the sixteen special operations that read or write these registers. It also performs two control transfers: entry into an exception handler and return from it. Instruction decode and the general register file sit outside. Decode presents a 4-bit operation code together with the value of a general register. It receives read results on a combinational data output, and it follows the registered redirect outputs.

An entry can come from a fault request that carries its own number, from the trap operation, or from one of the maskable interrupt lines. The interrupt lines are gated by enable bits in the low end of the live status word. On entry the live program counter and status are saved. The page register shifts its current page into its upper byte and starts over at page 0. The redirect target is the vector base plus twice the exception number. Return reverses the transfer. It also hands the scratch register back to decode so that decode can restore the register it names, which is normally the stack pointer.

Top module: `exc_sreg_unit`

## Requirements
- R1: After reset all special registers, `rdata`, `redirect`, `redirect_pc` and `redirect_sr` are zero.
- R2: With `op_valid` high, the read codes 4 (page register), 6 (saved PC), 8 (saved status), A (scratch), C (exception number, zero-extended) and E (vector base) drive the register value onto `rdata` in the same cycle. Every other code except 0 gives zero.
- R3: The write codes 5, 7, 9, B, D and F load `op_operand` into the page register, saved PC, saved status, scratch, exception number (low 8 bits) and vector base. The new value is readable from the next cycle on.
- R4: On an accepted entry the saved PC takes `pc_in`, the saved status takes `sr_in` and the exception number takes the entry's number, all at the same clock edge.
- R5: On entry the page register's upper byte takes the old lower byte and the lower byte becomes 0. This appears on `pch_out` one cycle after the request.
- R6: One cycle after an accepted entry, `redirect` is 1, `redirect_pc` is the vector base plus 2 × number (modulo 2^16), and `redirect_sr` is `sr_in` with bits 1:0 cleared and all other bits kept.
- R7: Interrupt line k (bit k of `irq_req`) is accepted only when bit k of `sr_in` is 1. Line 0 is enabled by bit 0 and line 1 by bit 1. A masked line changes no register and causes no redirect.
- R8: Priority is fault request, then trap (code 1), then line 0, then line 1. The trap number is `op_operand[7:0]` and is taken whatever the enable bits are. The fault number is `exc_num`. Line k uses number 2 + k.
- R9: Return (code 0) puts the scratch register on `rdata` in the same cycle. The next cycle gives `redirect`=1, `redirect_pc` equal to the saved PC and `redirect_sr` equal to the saved status. The page register's lower byte takes its upper byte.
- R10: Codes 2 and 3 change no special register. Any operation presented in a cycle where an entry is accepted, other than the trap that causes it, has no effect.
- R11: In a cycle after which neither an entry nor a return was accepted, `redirect`, `redirect_pc` and `redirect_sr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Special operation present |
| op_code | input | 4 | Special operation code |
| op_operand | input | 16 | General register value for writes and the trap number |
| exc_req | input | 1 | Fault exception request |
| exc_num | input | 8 | Number of the fault exception |
| irq_req | input | 2 | Maskable interrupt lines |
| pc_in | input | 16 | Program counter to resume at |
| sr_in | input | 16 | Live status word |
| rdata | output | 16 | Read result, or the scratch register on return |
| redirect | output | 1 | Control transfer this cycle |
| redirect_pc | output | 16 | New program counter |
| redirect_sr | output | 16 | New status word |
| pch_out | output | 16 | Page register (low byte is the live page) |

## Verification
The bench drives a fault, a trap and an interrupt in the same cycle to check the order of acceptance. It also raises both interrupt lines with each enable pattern. A swapped priority or a wrong mask would redirect to the wrong vector or take a masked line. It then follows an entry with a return and checks that the page bytes shift and come back. A design that moved the page in the wrong direction would resume on page 0 or on a stale page. Writes presented together with an accepted entry, and the push and pop codes, are read back afterwards. Any leak through those paths shows up as a changed register.

// File: rtl/esu_pkg.sv
package esu_pkg;
  typedef enum logic [3:0] {
    OP_RETI   = 4'h0, OP_TRAP   = 4'h1, OP_PUSH   = 4'h2, OP_POP    = 4'h3,
    OP_GETPCH = 4'h4, OP_SETPCH = 4'h5, OP_GETEPC = 4'h6, OP_SETEPC = 4'h7,
    OP_GETESR = 4'h8, OP_SETESR = 4'h9, OP_GETUER = 4'hA, OP_SETUER = 4'hB,
    OP_GETNUM = 4'hC, OP_SETNUM = 4'hD, OP_GETVBR = 4'hE, OP_SETVBR = 4'hF
  } sop_e;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_FAULT, SRC_TRAP, SRC_IRQ
  } src_e;
endpackage

// File: rtl/esu_rst_sync.sv
module esu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/esu_arbiter.sv
module esu_arbiter
  import esu_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_W    = 8,
  parameter int N_IRQ    = 2,
  parameter int IRQ_BASE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] op_operand,
  input  logic              exc_req,
  input  logic [NUM_W-1:0]  exc_num,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic [DATA_W-1:0] sr_in,
  output logic              take,
  output logic [NUM_W-1:0]  take_num,
  output src_e              take_src
);
  logic [N_IRQ-1:0] irq_live;
  logic             irq_hit;
  logic [NUM_W-1:0] irq_num;
  logic             trap_op;

  genvar g;
  generate
    for (g = 0; g < N_IRQ; g++) begin : g_mask
      assign irq_live[g] = irq_req[g] & sr_in[g];
    end
  endgenerate

  always_comb begin
    irq_hit = 1'b0;
    irq_num = '0;
    for (int k = N_IRQ - 1; k >= 0; k--) begin
      if (irq_live[k]) begin
        irq_hit = 1'b1;
        irq_num = NUM_W'(IRQ_BASE + k);
      end
    end
  end

  assign trap_op = op_valid && (op_code == OP_TRAP);

  always_comb begin
    take     = 1'b1;
    take_num = '0;
    take_src = SRC_NONE;
    if (exc_req) begin
      take_num = exc_num;
      take_src = SRC_FAULT;
    end else if (trap_op) begin
      take_num = op_operand[NUM_W-1:0];
      take_src = SRC_TRAP;
    end else if (irq_hit) begin
      take_num = irq_num;
      take_src = SRC_IRQ;
    end else begin
      take = 1'b0;
    end
  end

  // R7
  masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && !trap_op && ((irq_req & sr_in[N_IRQ-1:0]) == '0)) |-> !take);

  // R8
  trap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && trap_op) |-> (take && take_num == op_operand[NUM_W-1:0]));
endmodule

// File: rtl/esu_regs.sv
module esu_regs
  import esu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] op_operand,
  input  logic              take,
  input  logic [NUM_W-1:0]  take_num,
  input  logic [DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0] sr_in,
  output logic [DATA_W-1:0] pch,
  output logic [DATA_W-1:0] epc,
  output logic [DATA_W-1:0] esr,
  output logic [DATA_W-1:0] uer,
  output logic [NUM_W-1:0]  enum_r,
  output logic [DATA_W-1:0] vbr,
  output logic              reti_go
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] pch_d, epc_d, esr_d, uer_d, vbr_d;
  logic [NUM_W-1:0]  enum_d;
  logic              pch_en, epc_en, esr_en, uer_en, enum_en, vbr_en;
  logic              op_go;

  assign op_go   = op_valid && !take;
  assign reti_go = op_go && (op_code == OP_RETI);

  always_comb begin
    pch_d  = pch;  epc_d = epc;  esr_d = esr;
    uer_d  = uer;  vbr_d = vbr;  enum_d = enum_r;
    pch_en = 1'b0; epc_en = 1'b0; esr_en = 1'b0;
    uer_en = 1'b0; enum_en = 1'b0; vbr_en = 1'b0;
    if (take) begin
      pch_d   = {pch[HALF_W-1:0], {HALF_W{1'b0}}};
      epc_d   = pc_in;
      esr_d   = sr_in;
      enum_d  = take_num;
      pch_en  = 1'b1; epc_en = 1'b1; esr_en = 1'b1; enum_en = 1'b1;
    end else if (op_go) begin
      unique case (sop_e'(op_code))
        OP_RETI: begin
          pch_d  = {pch[DATA_W-1:HALF_W], pch[DATA_W-1:HALF_W]};
          pch_en = 1'b1;
        end
        OP_SETPCH: begin pch_d  = op_operand;              pch_en  = 1'b1; end
        OP_SETEPC: begin epc_d  = op_operand;              epc_en  = 1'b1; end
        OP_SETESR: begin esr_d  = op_operand;              esr_en  = 1'b1; end
        OP_SETUER: begin uer_d  = op_operand;              uer_en  = 1'b1; end
        OP_SETNUM: begin enum_d = op_operand[NUM_W-1:0];   enum_en = 1'b1; end
        OP_SETVBR: begin vbr_d  = op_operand;              vbr_en  = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pch <= '0; epc <= '0; esr <= '0; uer <= '0; enum_r <= '0; vbr <= '0;
    end else begin
      if (pch_en)  pch    <= pch_d;
      if (epc_en)  epc    <= epc_d;
      if (esr_en)  esr    <= esr_d;
      if (uer_en)  uer    <= uer_d;
      if (enum_en) enum_r <= enum_d;
      if (vbr_en)  vbr    <= vbr_d;
    end
  end

  // R4
  entry_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (epc == $past(pc_in) && esr == $past(sr_in) && enum_r == $past(take_num)));

  // R5
  page_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (pch[HALF_W-1:0] == '0 && pch[DATA_W-1:HALF_W] == $past(pch[HALF_W-1:0])));

  // R10
  stack_op_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go && (op_code == OP_PUSH || op_code == OP_POP)) |=>
      ($stable(pch) && $stable(epc) && $stable(esr) && $stable(uer) &&
       $stable(enum_r) && $stable(vbr)));

  // R9
  reti_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reti_go |=> (pch[HALF_W-1:0] == $past(pch[DATA_W-1:HALF_W])));
endmodule

// File: rtl/esu_readmux.sv
module esu_readmux
  import esu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_W  = 8
) (
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] pch,
  input  logic [DATA_W-1:0] epc,
  input  logic [DATA_W-1:0] esr,
  input  logic [DATA_W-1:0] uer,
  input  logic [NUM_W-1:0]  enum_r,
  input  logic [DATA_W-1:0] vbr,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (op_valid) begin
      unique case (sop_e'(op_code))
        OP_RETI,
        OP_GETUER: rdata = uer;
        OP_GETPCH: rdata = pch;
        OP_GETEPC: rdata = epc;
        OP_GETESR: rdata = esr;
        OP_GETNUM: rdata = DATA_W'(enum_r);
        OP_GETVBR: rdata = vbr;
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/esu_redirect.sv
module esu_redirect #(
  parameter int DATA_W = 16,
  parameter int NUM_W  = 8,
  parameter int N_IRQ  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [NUM_W-1:0]  take_num,
  input  logic              reti_go,
  input  logic [DATA_W-1:0] vbr,
  input  logic [DATA_W-1:0] epc,
  input  logic [DATA_W-1:0] esr,
  input  logic [DATA_W-1:0] sr_in,
  output logic              redirect,
  output logic [DATA_W-1:0] redirect_pc,
  output logic [DATA_W-1:0] redirect_sr
);
  localparam logic [DATA_W-1:0] IE_MASK = DATA_W'((1 << N_IRQ) - 1);

  logic              red_d;
  logic [DATA_W-1:0] pc_d, sr_d;

  always_comb begin
    red_d = 1'b0;
    pc_d  = '0;
    sr_d  = '0;
    if (take) begin
      red_d = 1'b1;
      pc_d  = vbr + (DATA_W'(take_num) << 1);
      sr_d  = sr_in & ~IE_MASK;
    end else if (reti_go) begin
      red_d = 1'b1;
      pc_d  = epc;
      sr_d  = esr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect    <= 1'b0;
      redirect_pc <= '0;
      redirect_sr <= '0;
    end else begin
      redirect    <= red_d;
      redirect_pc <= pc_d;
      redirect_sr <= sr_d;
    end
  end

  // R6
  entry_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (redirect && (redirect_sr & IE_MASK) == '0));

  // R9
  reti_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reti_go |=> (redirect && redirect_pc == $past(epc) && redirect_sr == $past(esr)));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !reti_go) |=> (!redirect && redirect_pc == '0 && redirect_sr == '0));
endmodule

// File: rtl/exc_sreg_unit.sv
module exc_sreg_unit
  import esu_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_W    = 8,
  parameter int N_IRQ    = 2,
  parameter int IRQ_BASE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] op_operand,
  input  logic              exc_req,
  input  logic [NUM_W-1:0]  exc_num,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic [DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0] sr_in,
  output logic [DATA_W-1:0] rdata,
  output logic              redirect,
  output logic [DATA_W-1:0] redirect_pc,
  output logic [DATA_W-1:0] redirect_sr,
  output logic [DATA_W-1:0] pch_out
);
  logic              rst_sync_n;
  logic              take, reti_go;
  logic [NUM_W-1:0]  take_num;
  src_e              take_src;
  logic [DATA_W-1:0] pch, epc, esr, uer, vbr;
  logic [NUM_W-1:0]  enum_r;

  esu_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  esu_arbiter #(.DATA_W(DATA_W), .NUM_W(NUM_W), .N_IRQ(N_IRQ), .IRQ_BASE(IRQ_BASE)) u_arb (
    .clk(clk), .rst_n(rst_sync_n), .op_valid(op_valid), .op_code(op_code),
    .op_operand(op_operand), .exc_req(exc_req), .exc_num(exc_num),
    .irq_req(irq_req), .sr_in(sr_in), .take(take), .take_num(take_num),
    .take_src(take_src)
  );

  esu_regs #(.DATA_W(DATA_W), .NUM_W(NUM_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .op_valid(op_valid), .op_code(op_code),
    .op_operand(op_operand), .take(take), .take_num(take_num),
    .pc_in(pc_in), .sr_in(sr_in), .pch(pch), .epc(epc), .esr(esr),
    .uer(uer), .enum_r(enum_r), .vbr(vbr), .reti_go(reti_go)
  );

  esu_readmux #(.DATA_W(DATA_W), .NUM_W(NUM_W)) u_rd (
    .op_valid(op_valid), .op_code(op_code), .pch(pch), .epc(epc),
    .esr(esr), .uer(uer), .enum_r(enum_r), .vbr(vbr), .rdata(rdata)
  );

  esu_redirect #(.DATA_W(DATA_W), .NUM_W(NUM_W), .N_IRQ(N_IRQ)) u_red (
    .clk(clk), .rst_n(rst_sync_n), .take(take), .take_num(take_num),
    .reti_go(reti_go), .vbr(vbr), .epc(epc), .esr(esr), .sr_in(sr_in),
    .redirect(redirect), .redirect_pc(redirect_pc), .redirect_sr(redirect_sr)
  );

  assign pch_out = pch;

  // R8
  fault_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exc_req |-> (take && take_src == SRC_FAULT && take_num == exc_num));
endmodule

// File: tb/exc_sreg_unit_test.sv
module exc_sreg_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = 4'h0;
  logic [15:0] op_operand = 16'h0;
  logic        exc_req = 1'b0;
  logic [7:0]  exc_num = 8'h0;
  logic [1:0]  irq_req = 2'b00;
  logic [15:0] pc_in = 16'h0;
  logic [15:0] sr_in = 16'h0;
  logic [15:0] rdata, redirect_pc, redirect_sr, pch_out;
  logic        redirect;

  int n_tests = 0;
  int n_fail  = 0;
  bit cmp_en  = 1'b0;

  // reference state
  logic [15:0] m_pch, m_epc, m_esr, m_uer, m_vbr, m_rpc, m_rsr;
  logic [7:0]  m_num;
  logic        m_red;

  exc_sreg_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_operand(op_operand), .exc_req(exc_req), .exc_num(exc_num),
    .irq_req(irq_req), .pc_in(pc_in), .sr_in(sr_in), .rdata(rdata),
    .redirect(redirect), .redirect_pc(redirect_pc), .redirect_sr(redirect_sr),
    .pch_out(pch_out)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] m_rdata();
    if (!op_valid) return 16'h0;
    case (op_code)
      4'h0, 4'hA: return m_uer;
      4'h4: return m_pch;
      4'h6: return m_epc;
      4'h8: return m_esr;
      4'hC: return {8'h00, m_num};
      4'hE: return m_vbr;
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pch = 0; m_epc = 0; m_esr = 0; m_uer = 0; m_vbr = 0; m_num = 0;
      m_red = 0; m_rpc = 0; m_rsr = 0;
    end else begin
      bit t; logic [7:0] n;
      t = 1'b1; n = 8'h0;
      if (exc_req) n = exc_num;
      else if (op_valid && op_code == 4'h1) n = op_operand[7:0];
      else if (irq_req[0] && sr_in[0]) n = 8'd2;
      else if (irq_req[1] && sr_in[1]) n = 8'd3;
      else t = 1'b0;
      m_red = 0; m_rpc = 0; m_rsr = 0;
      if (t) begin
        m_epc = pc_in; m_esr = sr_in; m_num = n;
        m_pch = {m_pch[7:0], 8'h00};
        m_red = 1; m_rpc = m_vbr + {7'h0, n, 1'b0}; m_rsr = sr_in & 16'hFFFC;
      end else if (op_valid) begin
        case (op_code)
          4'h0: begin m_red = 1; m_rpc = m_epc; m_rsr = m_esr; m_pch = {m_pch[15:8], m_pch[15:8]}; end
          4'h5: m_pch = op_operand;
          4'h7: m_epc = op_operand;
          4'h9: m_esr = op_operand;
          4'hB: m_uer = op_operand;
          4'hD: m_num = op_operand[7:0];
          4'hF: m_vbr = op_operand;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R2 rdata", rdata, m_rdata());
      chk("R11 redirect", {15'h0, redirect}, {15'h0, m_red});
      chk("R6 redirect_pc", redirect_pc, m_rpc);
      chk("R6 redirect_sr", redirect_sr, m_rsr);
      chk("R5 pch_out", pch_out, m_pch);
    end
  end

  task automatic step(input logic v, input logic [3:0] c, input logic [15:0] opnd,
                      input logic e, input logic [7:0] en, input logic [1:0] irq,
                      input logic [15:0] pc, input logic [15:0] sr);
    @(posedge clk); #1;
    op_valid = v; op_code = c; op_operand = opnd; exc_req = e; exc_num = en;
    irq_req = irq; pc_in = pc; sr_in = sr;
  endtask

  task automatic idle();
    step(0, 4'h0, 16'h0, 0, 8'h0, 2'b00, 16'h0, 16'h0);
  endtask

  // read a register through the port in its own cycle
  task automatic rd(input string tag, input logic [3:0] c, input logic [15:0] exp);
    step(1, c, 16'h0, 0, 8'h0, 2'b00, 16'h0, 16'h0);
    #2 chk(tag, rdata, exp);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++; n_tests++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 cmp_en = 1'b1;
    #2;
    // R1 reset state
    chk("R1 redirect", {15'h0, redirect}, 16'h0);
    chk("R1 pch", pch_out, 16'h0);
    rd("R1 epc", 4'h6, 16'h0);
    rd("R1 vbr", 4'hE, 16'h0);

    // R3 writes
    step(1, 4'hF, 16'h0100, 0, 0, 0, 0, 0);
    step(1, 4'hB, 16'hBEEF, 0, 0, 0, 0, 0);
    step(1, 4'h5, 16'h0005, 0, 0, 0, 0, 0);
    rd("R3 vbr", 4'hE, 16'h0100);
    rd("R3 uer", 4'hA, 16'hBEEF);
    rd("R2 pch", 4'h4, 16'h0005);

    // R4 R5 R6 fault entry
    step(0, 4'h0, 16'h0, 1, 8'h07, 2'b00, 16'h1234, 16'h7F1F);
    idle(); #2;
    chk("R6 pc", redirect_pc, 16'h010E);
    chk("R6 sr", redirect_sr, 16'h7F1C);
    chk("R5 pch", pch_out, 16'h0500);
    rd("R4 epc", 4'h6, 16'h1234);
    rd("R4 esr", 4'h8, 16'h7F1F);
    rd("R4 num", 4'hC, 16'h0007);

    // R9 return
    step(1, 4'h0, 16'h0, 0, 0, 2'b00, 0, 0);
    #2 chk("R9 rdata", rdata, 16'hBEEF);
    idle(); #2;
    chk("R9 pc", redirect_pc, 16'h1234);
    chk("R9 sr", redirect_sr, 16'h7F1F);
    chk("R9 pch", pch_out, 16'h0505);

    // R7 masked lines
    step(0, 4'h0, 16'h0, 0, 0, 2'b11, 16'h4444, 16'h0000);
    idle(); #2;
    chk("R7 no redirect", {15'h0, redirect}, 16'h0);
    rd("R7 epc kept", 4'h6, 16'h1234);

    // R8 line 0 over line 1
    step(0, 4'h0, 16'h0, 0, 0, 2'b11, 16'h2000, 16'h0003);
    idle(); #2 chk("R8 irq0 vec", redirect_pc, 16'h0104);
    // R7 line 1 alone enabled
    step(0, 4'h0, 16'h0, 0, 0, 2'b11, 16'h2002, 16'h0002);
    idle(); #2 chk("R7 irq1 vec", redirect_pc, 16'h0106);
    // R8 trap beats enabled line, ignores enables
    step(1, 4'h1, 16'h0009, 0, 0, 2'b01, 16'h3000, 16'h0001);
    idle(); #2 chk("R8 trap vec", redirect_pc, 16'h0112);
    // R8 fault beats trap
    step(1, 4'h1, 16'h0009, 1, 8'h05, 2'b00, 16'h3002, 16'h0000);
    idle(); #2 chk("R8 fault vec", redirect_pc, 16'h010A);

    // R10 stack codes and a write lost to an entry
    step(1, 4'h2, 16'hAAAA, 0, 0, 0, 0, 0);
    step(1, 4'h3, 16'h5555, 0, 0, 0, 0, 0);
    step(1, 4'hB, 16'h1111, 1, 8'h01, 2'b00, 16'h0, 16'h0);
    rd("R10 uer kept", 4'hA, 16'hBEEF);
    rd("R10 vbr kept", 4'hE, 16'h0100);

    // vector wrap (R6)
    step(1, 4'hF, 16'hFFF0, 0, 0, 0, 0, 0);
    step(1, 4'h1, 16'h00FF, 0, 0, 0, 16'h0, 16'h8000);
    idle(); #2 chk("R6 wrap", redirect_pc, 16'h01EE);

    // mixed stimulus against the reference
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 15);
      step($urandom_range(0, 3) != 0, 4'($urandom), 16'($urandom),
           r == 0, 8'($urandom), (r < 4) ? 2'($urandom) : 2'b00,
           16'($urandom), 16'($urandom));
    end
    idle(); idle();
    #2;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule